// File: doc/BRIEF.md
# Masked Event Interrupt Unit

This block gathers power-management events into an 8-bit pending register and combines them with an 8-bit enable mask. It drives an active-low interrupt line to the host whenever an enabled event is pending. An internal counter raises a tick event once per second, measured in clock cycles. Other sources raise events with single-cycle pulses.

Replies from a peripheral bus arrive as a valid/ready byte stream. A reply is accepted only while no earlier reply is waiting and no response is being sent. `rpl_ready` stays low at those times and the producer must hold its beat. The final beat, marked by `rpl_last`, posts the reply. Bytes beyond the store depth are dropped.

The host issues commands on a valid/ready command port. An acknowledge command returns the pending byte and clears it. If a bus reply is waiting, the acknowledge instead returns a header byte followed by the stored reply. A set-mask command loads a new enable mask. Responses leave on a valid/ready stream. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold their values. No new command is taken until the last response byte has been accepted.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset the pending register is 0x00, the mask is 0x90 (bus-reply bit 4 and tick bit 7 enabled), `irq_n` is high, and `cmd_ready` and `rpl_ready` are high.
- R2: `irq_n` is low exactly when the bitwise AND of pending and mask is nonzero. It follows every change of either register by the next clock cycle.
- R3: A pulse on `evt_i` sets the matching pending bits at the next clock edge. If an event and an acknowledge clear hit the same bit in the same cycle, the bit ends up set.
- R4: The tick sets pending bit 7 every TICK_CYCLES clock cycles, first at edge TICK_CYCLES after reset. Each deadline is the previous one plus TICK_CYCLES, so servicing does not shift later ticks.
- R5: A reply beat is accepted only while pending bit 4 is clear and no response is in progress. The beat with `rpl_last` high sets bit 4. If `rpl_auto` is also high on that beat, it sets bit 2 as well.
- R6: An acknowledge while bit 4 is set returns a header byte (pending AND 0x14) followed by the stored reply bytes. It clears only bits 4 and 2, empties the store, and leaves the other pending bits unchanged.
- R7: An acknowledge while bit 4 is clear returns one byte equal to the whole pending register and clears every pending bit.
- R8: If bit 4 is set while the reply store is empty, the acknowledge returns the header byte alone.
- R9: Opcode `cmd_op`=0 is acknowledge and requires `cmd_argc`=0. Opcode 1 is set-mask and requires `cmd_argc`=1, loading `cmd_arg` into the mask. Any other argument count changes no state and produces no response.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold steady. `cmd_ready` stays low until the final response byte, flagged by `rsp_last`, is accepted.
- R11: The reply store holds REPLY_DEPTH bytes. Bytes beyond that in one reply are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses, one per pending bit |
| rpl_valid | input | 1 | Reply byte valid |
| rpl_ready | output | 1 | Reply byte accepted this cycle |
| rpl_data | input | 8 | Reply byte |
| rpl_last | input | 1 | Final byte of reply |
| rpl_auto | input | 1 | Reply came from autopolling (sampled on last byte) |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 1 | 0 = acknowledge, 1 = set mask |
| cmd_argc | input | 3 | Argument count supplied with the command |
| cmd_arg | input | 8 | First argument byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response byte taken |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Several rules are checked every cycle. Enabled events pull the interrupt low on the next cycle. A waiting reply holds off the reply stream. A stalled response keeps its byte steady, and commands are refused while one is outgoing. A non-bus acknowledge empties the pending register, and a malformed set-mask leaves the mask alone. Only the bench scenarios can show the byte content and order of responses. They also cover which pending bits survive a bus-path acknowledge, dropping of overflow bytes, event-over-clear precedence, and the exact cycle spacing of successive ticks.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EVT_W    = 8;
  localparam int BIT_AUTO = 2;
  localparam int BIT_BUS  = 4;
  localparam int BIT_TICK = 7;
  localparam logic [EVT_W-1:0] BUS_GRP  = EVT_W'((1 << BIT_BUS) | (1 << BIT_AUTO));
  localparam logic [EVT_W-1:0] MASK_RST = EVT_W'((1 << BIT_BUS) | (1 << BIT_TICK));
  localparam logic OP_ACK  = 1'b0;
  localparam logic OP_MASK = 1'b1;
  typedef enum logic {SEQ_IDLE, SEQ_SEND} seq_state_e;
endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] LIM = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LIM);

  // deadline-based: reload is unconditional, independent of servicing
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_reply_store.sv
module evt_reply_store #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [W-1:0]                   wr_data,
  input  logic                           clr,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_addr,
  output logic [W-1:0]                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]     count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[AW'(cnt_q)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (wr_en && !full) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_rsp_seq.sv
module evt_rsp_seq
  import evt_irq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [W-1:0]                   hdr_i,
  input  logic [$clog2(DEPTH+1)-1:0]     nbytes_i,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_addr,
  input  logic [W-1:0]                   rd_data,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [W-1:0]                   rsp_data,
  output logic                           rsp_last,
  output logic                           busy_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  seq_state_e    state_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] last_q;
  logic [W-1:0]  hdr_q;

  assign busy_o    = (state_q == SEQ_SEND);
  assign rsp_valid = busy_o;
  assign rsp_last  = (idx_q == last_q);
  assign rd_addr   = AW'(idx_q - 1'b1);
  assign rsp_data  = (idx_q == '0) ? hdr_q : rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      hdr_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_SEND;
          idx_q   <= '0;
          last_q  <= nbytes_i;
          hdr_q   <= hdr_i;
        end
        SEQ_SEND: if (rsp_ready) begin
          if (idx_q == last_q) state_q <= SEQ_IDLE;
          else                 idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int TICK_CYCLES = 100_000_000,
  parameter int REPLY_DEPTH = 8,
  parameter int ARGC_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              rpl_valid,
  output logic              rpl_ready,
  input  logic [EVT_W-1:0]  rpl_data,
  input  logic              rpl_last,
  input  logic              rpl_auto,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ARGC_W-1:0] cmd_argc,
  input  logic [EVT_W-1:0]  cmd_arg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [EVT_W-1:0]  rsp_data,
  output logic              rsp_last,
  output logic              irq_n
);
  localparam int AW = (REPLY_DEPTH > 1) ? $clog2(REPLY_DEPTH) : 1;
  localparam int CW = $clog2(REPLY_DEPTH + 1);

  logic [EVT_W-1:0] pend_q, mask_q, pend_set, pend_clr;
  logic             tick_pulse, seq_busy, cmd_fire, ack_ok, mask_wr;
  logic             bus_path, rpl_fire, rpl_done;
  logic [AW-1:0]    rd_addr;
  logic [EVT_W-1:0] rd_data, hdr;
  logic [CW-1:0]    store_cnt;

  evt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_pulse)
  );

  assign bus_path  = pend_q[BIT_BUS];
  assign cmd_ready = !seq_busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign ack_ok    = cmd_fire && (cmd_op == OP_ACK)  && (cmd_argc == ARGC_W'(0));
  assign mask_wr   = cmd_fire && (cmd_op == OP_MASK) && (cmd_argc == ARGC_W'(1));
  assign rpl_ready = !bus_path && !seq_busy;
  assign rpl_fire  = rpl_valid && rpl_ready;
  assign rpl_done  = rpl_fire && rpl_last;

  evt_reply_store #(.W(EVT_W), .DEPTH(REPLY_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rpl_fire), .wr_data(rpl_data),
    .clr(ack_ok && bus_path),
    .rd_addr(rd_addr), .rd_data(rd_data), .count_o(store_cnt)
  );

  assign hdr = bus_path ? (pend_q & BUS_GRP) : pend_q;

  evt_rsp_seq #(.W(EVT_W), .DEPTH(REPLY_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(ack_ok), .hdr_i(hdr),
    .nbytes_i(bus_path ? store_cnt : CW'(0)),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last),
    .busy_o(seq_busy)
  );

  always_comb begin
    pend_clr = '0;
    if (ack_ok) pend_clr = bus_path ? BUS_GRP : '1;
    pend_set = evt_i;
    if (tick_pulse) pend_set[BIT_TICK] = 1'b1;
    if (rpl_done) begin
      pend_set[BIT_BUS] = 1'b1;
      if (rpl_auto) pend_set[BIT_AUTO] = 1'b1;
    end
  end

  // set applied after clear: a same-cycle event survives the acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      if (mask_wr) mask_q <= cmd_arg;
    end
  end

  assign irq_n = ~|(pend_q & mask_q);
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk
  import evt_irq_pkg::*;
#(
  parameter int ARGC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_W-1:0]  evt_i,
  input logic              tick_pulse,
  input logic [EVT_W-1:0]  pend_q,
  input logic [EVT_W-1:0]  mask_q,
  input logic              mask_wr,
  input logic              irq_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_op,
  input logic [ARGC_W-1:0] cmd_argc,
  input logic              rpl_valid,
  input logic              rpl_ready,
  input logic              rpl_last,
  input logic              rpl_auto,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [EVT_W-1:0]  rsp_data,
  input logic              rsp_last
);
  logic cmd_go, plain_ack, bad_mask, rpl_end;
  assign cmd_go    = cmd_valid && cmd_ready;
  assign plain_ack = cmd_go && cmd_op == OP_ACK && cmd_argc == ARGC_W'(0) && !pend_q[BIT_BUS];
  assign bad_mask  = cmd_go && cmd_op == OP_MASK && cmd_argc != ARGC_W'(1);
  assign rpl_end   = rpl_valid && rpl_ready && rpl_last;

  // R2
  masked_evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_i & mask_q)) && !mask_wr) |=> !irq_n);
  // R5
  reply_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[BIT_BUS] |-> !rpl_ready);
  // R5
  auto_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_end && rpl_auto) |=> (pend_q[BIT_BUS] && pend_q[BIT_AUTO]));
  // R7
  plain_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_ack && evt_i == '0 && !tick_pulse && !rpl_end) |=> (pend_q == '0));
  // R9
  bad_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mask |=> $stable(mask_q));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));
  // R10
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
endmodule

bind evt_irq_unit evt_irq_unit_chk #(.ARGC_W(ARGC_W)) u_chk (.*);

// File: tb/sim_evt_irq_unit.sv
module sim_evt_irq_unit;
  localparam int TICK  = 3000;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] evt_i = '0, rpl_data = '0, cmd_arg = '0, rsp_data;
  logic rpl_valid = 0, rpl_last = 0, rpl_auto = 0, cmd_valid = 0, cmd_op = 0, rsp_ready = 1;
  logic [2:0] cmd_argc = '0;
  logic rpl_ready, cmd_ready, rsp_valid, rsp_last, irq_n;

  always #2 clk = ~clk;

  evt_irq_unit #(.TICK_CYCLES(TICK), .REPLY_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
    .rpl_last(rpl_last), .rpl_auto(rpl_auto),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_argc(cmd_argc), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .irq_n(irq_n)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, got_n = 0;
  logic [7:0] got [16];
  logic [7:0] rb [8];
  logic [7:0] ex [8];

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  // kind[22:21] 0=event 1=mask 2=ack | argc[20:18] | data[17:10] | irq_n[9] | has_rsp[8] | rsp[7:0]
  localparam logic [22:0] VEC [16] = '{
    {2'd0, 3'd0, 8'h01, 1'b1, 1'b0, 8'h00},
    {2'd2, 3'd0, 8'h00, 1'b1, 1'b1, 8'h01},
    {2'd0, 3'd0, 8'h80, 1'b0, 1'b0, 8'h00},
    {2'd1, 3'd1, 8'h00, 1'b1, 1'b0, 8'h00},
    {2'd1, 3'd2, 8'hFF, 1'b1, 1'b0, 8'h00},
    {2'd0, 3'd0, 8'h22, 1'b1, 1'b0, 8'h00},
    {2'd1, 3'd1, 8'h20, 1'b0, 1'b0, 8'h00},
    {2'd2, 3'd1, 8'h00, 1'b0, 1'b0, 8'h00},
    {2'd2, 3'd0, 8'h00, 1'b1, 1'b1, 8'hA2},
    {2'd1, 3'd1, 8'h41, 1'b1, 1'b0, 8'h00},
    {2'd0, 3'd0, 8'h40, 1'b0, 1'b0, 8'h00},
    {2'd2, 3'd0, 8'h00, 1'b1, 1'b1, 8'h40},
    {2'd1, 3'd0, 8'h90, 1'b1, 1'b0, 8'h00},
    {2'd0, 3'd0, 8'h01, 1'b0, 1'b0, 8'h00},
    {2'd2, 3'd0, 8'h00, 1'b1, 1'b1, 8'h01},
    {2'd1, 3'd1, 8'h90, 1'b1, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic collect();
    bit fin = 0;
    got_n = 0;
    for (int k = 0; k < 10; k++) begin
      if (!fin && rsp_valid && rsp_ready) begin
        got[got_n] = rsp_data;
        got_n++;
        if (rsp_last) fin = 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_cmd(input logic op, input logic [2:0] argc, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_argc = argc; cmd_arg = arg;
    @(negedge clk); cmd_valid = 0;
    collect();
  endtask

  task automatic expect_rsp(input string req, input int n);
    chk(req, got_n, n);
    for (int i = 0; i < n && i < got_n; i++) chk(req, got[i], ex[i]);
  endtask

  task automatic send_reply(input int n, input logic au);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rpl_valid = 1; rpl_data = rb[i]; rpl_last = (i == n - 1); rpl_auto = au;
      while (!rpl_ready) @(negedge clk);
      @(negedge clk);
    end
    rpl_valid = 0; rpl_last = 0; rpl_auto = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq_n", irq_n, 1); chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 rpl_ready", rpl_ready, 1); chk("R1 rsp_valid", rsp_valid, 0);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h00; expect_rsp("R1 pending zero", 1);
    // R8 bus bit without stored reply, enabled by reset mask
    pulse(8'h10); chk("R1 mask bit4", irq_n, 0);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h10; expect_rsp("R8 header alone", 1);
    pulse(8'h80); chk("R1 mask bit7", irq_n, 0);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h80; expect_rsp("R7 ack", 1);
    pulse(8'h08); chk("R2 unmasked bit", irq_n, 1);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h08; expect_rsp("R7 ack", 1);
    chk("R2 cleared", irq_n, 1);

    // R4 first tick
    while (cyc != TICK - 1) @(negedge clk);
    chk("R4 before tick", irq_n, 1);
    @(negedge clk); chk("R4 tick", irq_n, 0);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h80; expect_rsp("R4 tick bit", 1);

    for (int v = 0; v < 16; v++) begin
      logic [1:0] kind; logic [2:0] argc; logic [7:0] dat;
      string tag;
      kind = VEC[v][22:21]; argc = VEC[v][20:18]; dat = VEC[v][17:10];
      case (kind)
        2'd0: begin pulse(dat); tag = "R3 event"; end
        2'd1: begin do_cmd(1'b1, argc, dat); tag = "R9 set mask"; end
        default: begin do_cmd(1'b0, argc, dat); tag = (argc == 0) ? "R7 ack" : "R9 bad ack"; end
      endcase
      chk({tag, " irq_n"}, irq_n, VEC[v][9]);
      if (kind != 2'd0) begin
        chk({tag, " rsp count"}, got_n, VEC[v][8] ? 1 : 0);
        if (VEC[v][8] && got_n > 0) chk({tag, " rsp byte"}, got[0], VEC[v][7:0]);
      end
    end

    // R5 / R6 / R10 reply path
    pulse(8'h41); chk("R2 masked out", irq_n, 1);
    rb[0] = 8'hAA; rb[1] = 8'hBB; rb[2] = 8'hCC;
    send_reply(3, 1'b0);
    chk("R5 bus bit irq", irq_n, 0); chk("R5 ready low", rpl_ready, 0);
    rpl_valid = 1; rpl_data = 8'hDD; rpl_last = 1; rpl_auto = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R5 blocked", rpl_ready, 0);
    end
    rpl_valid = 0; rpl_last = 0; rpl_auto = 0;
    rsp_ready = 0;
    @(negedge clk); cmd_valid = 1; cmd_op = 0; cmd_argc = 0;
    @(negedge clk); cmd_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 valid held", rsp_valid, 1); chk("R10 data held", rsp_data, 8'h10);
      chk("R10 cmd blocked", cmd_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1;
    collect();
    ex[0] = 8'h10; ex[1] = 8'hAA; ex[2] = 8'hBB; ex[3] = 8'hCC;
    expect_rsp("R6 bus packet", 4);
    chk("R10 cmd free", cmd_ready, 1);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h41; expect_rsp("R6 others kept", 1);

    rb[0] = 8'h11; rb[1] = 8'h22;
    send_reply(2, 1'b1); chk("R5 auto irq", irq_n, 0);
    do_cmd(1'b0, 3'd0, 8'h00);
    ex[0] = 8'h14; ex[1] = 8'h11; ex[2] = 8'h22; expect_rsp("R5 autopoll header", 3);

    for (int i = 0; i < 6; i++) rb[i] = 8'(i + 1);
    send_reply(6, 1'b0);
    do_cmd(1'b0, 3'd0, 8'h00);
    ex[0] = 8'h10; ex[1] = 8'h01; ex[2] = 8'h02; ex[3] = 8'h03; ex[4] = 8'h04;
    expect_rsp("R11 overflow dropped", 5);

    // R3 event beats same-cycle clear
    pulse(8'h20);
    cmd_valid = 1; cmd_op = 0; cmd_argc = 0; evt_i = 8'h22;
    @(negedge clk); cmd_valid = 0; evt_i = '0;
    collect(); ex[0] = 8'h20; expect_rsp("R3 snapshot", 1);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h22; expect_rsp("R3 event wins", 1);

    // R4 second tick exactly one period later
    chk("R4 schedule", (cyc < 2 * TICK - 1) ? 1 : 0, 1);
    while (cyc < 2 * TICK - 1) @(negedge clk);
    chk("R4 no early tick", irq_n, 1);
    @(negedge clk); chk("R4 second tick", irq_n, 0);
    do_cmd(1'b0, 3'd0, 8'h00); ex[0] = 8'h80; expect_rsp("R4 second tick bit", 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule